// File: doc/BRIEF.md
# Strap Capture and Clock Configuration

This block sits between the board straps, the serial configuration registers and the clock generator core. Five pins have two jobs. While power-on reset is held they carry strap levels: a 3-bit frequency code, a pin-function mode and a CPU buffer voltage select. The block keeps these five levels from reset release until the next reset. After that it lets the same pins drive clocks.

Software writes a bank of configuration bytes one byte at a time. The block merges those bytes with the kept straps. From them it produces the active frequency code and the nominal CPU, PCI and AGP frequencies for that code. It also produces the spread-spectrum controls, a global tristate request and the mobile/desktop pin-function flag. Last, it produces a 26-bit per-output enable vector for the drivers. In mobile mode, four shared pins act as power-management inputs instead of memory clock outputs. Their output enables and their enable bits are then suppressed.

Top module: `strap_clk_cfg`

## Requirements
- R1: The strap inputs are sampled at the first rising clock edge after `rst_ni` goes high. Later strap changes have no effect until the next reset.
- R2: `strap_oe_o` is 0 while `rst_ni` is low. It becomes 1 after the sampling edge and stays 1 until the next reset.
- R3: If byte 0 bit 3 is 0, `freq_sel_o` equals the sampled 3-bit frequency strap. If it is 1, `freq_sel_o` equals byte 0 bits 6:4. Byte 0 resets to 0x10.
- R4: The frequencies, in units of 10 kHz, follow `freq_sel_o`. Each entry is listed as code: CPU/PCI/AGP.
  - 0: 6000/3000/6000
  - 1: 6667/3333/6667
  - 2: 9622/3207/6415
  - 3: 9150/3050/6100
  - 4: 9700/3233/6466
  - 5: 8330/3330/6660
  - 6: 9525/3175/6350
  - 7: 10000/3333/6667
- R5: `spread_en_o` equals byte 0 bit 1. `spread_prof_o` is {byte 0 bit 7, byte 0 bit 2}, encoded as follows:
  - 00: down 0.5 %
  - 01: center 0.375 %
  - 10: center 0.25 %
  - 11: center 0.15 %
- R6: `tristate_o` equals byte 0 bit 0.
- R7: A sampled mode strap of 0 means mobile: `mobile_o`=1 and `pm_oe_o`=0. A sampled mode strap of 1 means desktop: `mobile_o`=0 and `pm_oe_o`=4'hF once `strap_oe_o` is 1.
- R8: `clk_en_o` bit positions:
  - [2:0]: CPU0-2, from byte 1 bits 2:0
  - [7:3]: PCI0-4, from byte 2 bits 4:0
  - [8]: PCI free-running, from byte 2 bit 6
  - [16:9]: SDRAM0-7, from byte 3 bits 7:0
  - [20:17]: SDRAM8-11, from byte 4 bits 3:0
  - [21]: SDRAM12, from byte 1 bit 4
  - [22]: AGP0, from byte 5 bit 4
  - [23]: AGP1, from byte 5 bit 1
  - [24]: AGP free-running, from byte 4 bit 7
  - [25]: REF, from byte 5 bit 0
  
  Bytes 1 to 5 reset to 0xFF.
- R9: In mobile mode, `clk_en_o[20:17]` are 0 whatever the byte 4 bits hold.
- R10: A write with `wr_idx_i` of 6 or more changes no output.
- R11: `vsel_o` holds the sampled CPU voltage strap.
- R12: A byte written with `wr_en_i` at a clock edge appears at the outputs right after that edge. All fields of that byte change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| strap_fs_i | input | 3 | Raw frequency strap levels |
| strap_mode_i | input | 1 | Raw mode strap level (0 mobile, 1 desktop) |
| strap_vsel_i | input | 1 | Raw CPU buffer voltage strap level |
| wr_en_i | input | 1 | Byte write strobe |
| wr_idx_i | input | 3 | Byte index to write |
| wr_data_i | input | 8 | Byte value |
| strap_oe_o | output | 1 | Shared strap pins drive clocks |
| pm_oe_o | output | 4 | Drive enables of the four mode-dependent pins |
| freq_sel_o | output | 3 | Active frequency code |
| cpu_f_o | output | 14 | CPU frequency, 10 kHz units |
| pci_f_o | output | 14 | PCI frequency, 10 kHz units |
| agp_f_o | output | 14 | AGP frequency, 10 kHz units |
| spread_en_o | output | 1 | Spread spectrum enable |
| spread_prof_o | output | 2 | Spread profile |
| tristate_o | output | 1 | Tristate all clock outputs |
| mobile_o | output | 1 | Mobile pin-function mode |
| vsel_o | output | 1 | Sampled CPU voltage select |
| clk_en_o | output | 26 | Per-output run enables |

## Verification
A strap register that samples at the wrong time shows up at once. If it keeps following the pins after reset, `freq_sel_o` and the frequencies move in the first cycle after a pin change. If it samples during reset, the wrong code appears as soon as reset is released. A misrouted or stuck configuration bit shows in `clk_en_o` or the mode flags on the first sample after the write. Scrambled bit positions give a wrong enable vector rather than a subtle timing error. A mode decode fault shows as SDRAM8-11 enables or `pm_oe_o` that disagree with `mobile_o` right after reset.

// File: rtl/strap_clk_cfg_pkg.sv
package strap_clk_cfg_pkg;

  typedef struct packed {
    logic       vsel;
    logic       mode;
    logic [2:0] fs;
  } strap_t;

  typedef enum logic [1:0] {
    SPR_DOWN_500   = 2'b00,
    SPR_CTR_375    = 2'b01,
    SPR_CTR_250    = 2'b10,
    SPR_CTR_150    = 2'b11
  } spread_prof_e;

  localparam int unsigned NUM_CLK   = 26;
  localparam int unsigned EN_CPU    = 0;
  localparam int unsigned EN_PCI    = 3;
  localparam int unsigned EN_PCIF   = 8;
  localparam int unsigned EN_SDR    = 9;
  localparam int unsigned EN_SDR_PM = 17;
  localparam int unsigned EN_SDR12  = 21;
  localparam int unsigned EN_AGP0   = 22;
  localparam int unsigned EN_AGP1   = 23;
  localparam int unsigned EN_AGPF   = 24;
  localparam int unsigned EN_REF    = 25;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_clk_cfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  strap_t strap_i,
  output strap_t strap_o,
  output logic   done_o
);

  strap_t strap_q;
  logic   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      strap_q <= strap_i;
      done_q  <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign done_o  = done_q;

  // R1
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q)) |-> $stable(strap_q));

  // R2
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(done_q));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned IDX_W     = 3,
  parameter logic [7:0]  BYTE0_RST = 8'h10,
  parameter logic [7:0]  BYTEN_RST = 8'hFF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [7:0]             wr_data_i,
  output logic [NUM_BYTES*8-1:0] cfg_o
);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam logic [7:0] RST = (b == 0) ? BYTE0_RST : BYTEN_RST;
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q <= RST;
      else if (wr_en_i && (wr_idx_i == IDX_W'(b)))    q <= wr_data_i;
    end
    assign cfg_o[b*8 +: 8] = q;
  end

  // R10
  no_oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_idx_i) >= NUM_BYTES)) |=> $stable(cfg_o));

endmodule

// File: rtl/freq_lut.sv
module freq_lut #(
  parameter int unsigned F_W = 14
) (
  input  logic [2:0]     code_i,
  output logic [F_W-1:0] cpu_o,
  output logic [F_W-1:0] pci_o,
  output logic [F_W-1:0] agp_o
);

  always_comb begin
    unique case (code_i)
      3'd0: begin cpu_o = F_W'(6000);  pci_o = F_W'(3000); agp_o = F_W'(6000); end
      3'd1: begin cpu_o = F_W'(6667);  pci_o = F_W'(3333); agp_o = F_W'(6667); end
      3'd2: begin cpu_o = F_W'(9622);  pci_o = F_W'(3207); agp_o = F_W'(6415); end
      3'd3: begin cpu_o = F_W'(9150);  pci_o = F_W'(3050); agp_o = F_W'(6100); end
      3'd4: begin cpu_o = F_W'(9700);  pci_o = F_W'(3233); agp_o = F_W'(6466); end
      3'd5: begin cpu_o = F_W'(8330);  pci_o = F_W'(3330); agp_o = F_W'(6660); end
      3'd6: begin cpu_o = F_W'(9525);  pci_o = F_W'(3175); agp_o = F_W'(6350); end
      default: begin cpu_o = F_W'(10000); pci_o = F_W'(3333); agp_o = F_W'(6667); end
    endcase
  end

endmodule

// File: rtl/strap_clk_cfg.sv
module strap_clk_cfg
  import strap_clk_cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned F_W       = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         strap_fs_i,
  input  logic               strap_mode_i,
  input  logic               strap_vsel_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  output logic               strap_oe_o,
  output logic [3:0]         pm_oe_o,
  output logic [2:0]         freq_sel_o,
  output logic [F_W-1:0]     cpu_f_o,
  output logic [F_W-1:0]     pci_f_o,
  output logic [F_W-1:0]     agp_f_o,
  output logic               spread_en_o,
  output logic [1:0]         spread_prof_o,
  output logic               tristate_o,
  output logic               mobile_o,
  output logic               vsel_o,
  output logic [NUM_CLK-1:0] clk_en_o
);

  strap_t                 strap_raw, strap_q;
  logic                   por_done;
  logic [NUM_BYTES*8-1:0] cfg;
  logic [7:0]             b0, b1, b2, b3, b4, b5;
  logic                   desktop;

  assign strap_raw = '{vsel: strap_vsel_i, mode: strap_mode_i, fs: strap_fs_i};

  strap_latch u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_raw),
    .strap_o (strap_q),
    .done_o  (por_done)
  );

  cfg_regs #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  assign b0 = cfg[0*8 +: 8];
  assign b1 = cfg[1*8 +: 8];
  assign b2 = cfg[2*8 +: 8];
  assign b3 = cfg[3*8 +: 8];
  assign b4 = cfg[4*8 +: 8];
  assign b5 = cfg[5*8 +: 8];

  assign freq_sel_o    = b0[3] ? b0[6:4] : strap_q.fs;
  assign spread_en_o   = b0[1];
  assign spread_prof_o = {b0[7], b0[2]};
  assign tristate_o    = b0[0];

  freq_lut #(.F_W(F_W)) u_lut (
    .code_i (freq_sel_o),
    .cpu_o  (cpu_f_o),
    .pci_o  (pci_f_o),
    .agp_o  (agp_f_o)
  );

  assign desktop    = strap_q.mode;
  assign mobile_o   = ~desktop;
  assign vsel_o     = strap_q.vsel;
  assign strap_oe_o = por_done;
  assign pm_oe_o    = {4{por_done & desktop}};

  always_comb begin
    clk_en_o                       = '0;
    clk_en_o[EN_CPU +: 3]          = b1[2:0];
    clk_en_o[EN_PCI +: 5]          = b2[4:0];
    clk_en_o[EN_PCIF]              = b2[6];
    clk_en_o[EN_SDR +: 8]          = b3;
    clk_en_o[EN_SDR_PM +: 4]       = b4[3:0] & {4{desktop}};
    clk_en_o[EN_SDR12]             = b1[4];
    clk_en_o[EN_AGP0]              = b5[4];
    clk_en_o[EN_AGP1]              = b5[1];
    clk_en_o[EN_AGPF]              = b4[7];
    clk_en_o[EN_REF]               = b5[0];
  end

  // R3
  reg_freq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0 && wr_data_i[3]) |=> (freq_sel_o == $past(wr_data_i[6:4])));

  // R6
  tristate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0) |=> (tristate_o == $past(wr_data_i[0])));

  // R9
  mobile_pm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mobile_o |-> (clk_en_o[EN_SDR_PM +: 4] == '0 && pm_oe_o == '0));

  // R7
  desktop_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_oe_o && !mobile_o) |-> (pm_oe_o == 4'hF));

endmodule

// File: tb/strap_clk_cfg_tb.sv
module strap_clk_cfg_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  strap_fs_i = '0;
  logic        strap_mode_i = 1'b0;
  logic        strap_vsel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        strap_oe_o;
  logic [3:0]  pm_oe_o;
  logic [2:0]  freq_sel_o;
  logic [13:0] cpu_f_o, pci_f_o, agp_f_o;
  logic        spread_en_o;
  logic [1:0]  spread_prof_o;
  logic        tristate_o, mobile_o, vsel_o;
  logic [25:0] clk_en_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  strap_clk_cfg u_dut (
    .clk_i, .rst_ni, .strap_fs_i, .strap_mode_i, .strap_vsel_i,
    .wr_en_i, .wr_idx_i, .wr_data_i, .strap_oe_o, .pm_oe_o, .freq_sel_o,
    .cpu_f_o, .pci_f_o, .agp_f_o, .spread_en_o, .spread_prof_o,
    .tristate_o, .mobile_o, .vsel_o, .clk_en_o
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] fs, input logic mode, input logic vsel);
    @(negedge clk_i);
    rst_ni = 1'b0;
    strap_fs_i = fs; strap_mode_i = mode; strap_vsel_i = vsel;
    repeat (2) @(negedge clk_i);
    check("R2 oe low in reset", strap_oe_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic check_freq(input string req, input logic [2:0] code,
                            input int c, input int p, input int a);
    check({req, " code"}, freq_sel_o, code);
    check({req, " cpu"}, cpu_f_o, c);
    check({req, " pci"}, pci_f_o, p);
    check({req, " agp"}, agp_f_o, a);
  endtask

  task automatic t_desktop_reset();
    do_reset(3'b101, 1'b1, 1'b1);
    check("R2 oe high", strap_oe_o, 1);
    check("R7 pm_oe desktop", pm_oe_o, 4'hF);
    check("R7 mobile flag", mobile_o, 0);
    check("R11 vsel", vsel_o, 1);
    check_freq("R1 R3 R4 strap", 3'd5, 8330, 3330, 6660);
    check("R8 enables reset", clk_en_o, 26'h3FFFFFF);
    check("R6 tristate reset", tristate_o, 0);
    check("R5 spread reset", spread_en_o, 0);
  endtask

  task automatic t_strap_ignored();
    strap_fs_i = 3'b000; strap_mode_i = 1'b0; strap_vsel_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 fs held", freq_sel_o, 3'd5);
    check("R1 mode held", mobile_o, 0);
    check("R11 vsel held", vsel_o, 1);
  endtask

  task automatic t_reg_freq();
    wr(3'd0, 8'h78);
    check_freq("R3 R4 R12 reg 7", 3'd7, 10000, 3333, 6667);
    wr(3'd0, 8'h08);
    check_freq("R4 reg 0", 3'd0, 6000, 3000, 6000);
    wr(3'd0, 8'h68);
    check_freq("R4 reg 6", 3'd6, 9525, 3175, 6350);
    wr(3'd0, 8'h28);
    check_freq("R4 reg 2", 3'd2, 9622, 3207, 6415);
    wr(3'd0, 8'h38);
    check_freq("R4 reg 3", 3'd3, 9150, 3050, 6100);
    wr(3'd0, 8'h48);
    check_freq("R4 reg 4", 3'd4, 9700, 3233, 6466);
    wr(3'd0, 8'h18);
    check_freq("R4 reg 1", 3'd1, 6667, 3333, 6667);
  endtask

  task automatic t_spread_tristate();
    wr(3'd0, 8'h86);
    check("R5 spread en", spread_en_o, 1);
    check("R5 profile", spread_prof_o, 2'b11);
    check("R6 tristate off", tristate_o, 0);
    check("R3 back to strap", freq_sel_o, 3'd5);
    wr(3'd0, 8'h05);
    check("R5 profile 01", spread_prof_o, 2'b01);
    check("R5 spread off", spread_en_o, 0);
    check("R6 tristate on", tristate_o, 1);
    wr(3'd0, 8'h10);
  endtask

  task automatic t_enables();
    wr(3'd3, 8'h00);
    check("R8 byte3", clk_en_o, 26'h3FE01FF);
    wr(3'd1, 8'h10);
    check("R8 byte1", clk_en_o, 26'h3FE01F8);
    wr(3'd2, 8'h40);
    check("R8 byte2", clk_en_o, 26'h3FE0100);
    wr(3'd4, 8'h80);
    check("R8 byte4", clk_en_o, 26'h3E00100);
    wr(3'd5, 8'h02);
    check("R8 byte5", clk_en_o, 26'h1A00100);
  endtask

  task automatic t_oob_write();
    wr(3'd6, 8'h00);
    check("R10 idx6 enables", clk_en_o, 26'h1A00100);
    check("R10 idx6 freq", freq_sel_o, 3'd5);
    wr(3'd7, 8'h0F);
    check("R10 idx7 enables", clk_en_o, 26'h1A00100);
    check("R10 idx7 tristate", tristate_o, 0);
  endtask

  task automatic t_mobile();
    do_reset(3'b010, 1'b0, 1'b0);
    check("R7 mobile flag", mobile_o, 1);
    check("R7 pm_oe mobile", pm_oe_o, 4'h0);
    check("R11 vsel low", vsel_o, 0);
    check_freq("R1 R4 mobile strap", 3'd2, 9622, 3207, 6415);
    check("R9 mobile enables", clk_en_o, 26'h3FFFFFF & ~(26'hF << 17));
    check("R8 regs reset after 2nd reset", spread_en_o, 0);
    wr(3'd4, 8'hFF);
    check("R9 byte4 ignored mobile", clk_en_o, 26'h3FFFFFF & ~(26'hF << 17));
  endtask

  initial begin
    fork
      begin
        t_desktop_reset();
        t_strap_ignored();
        t_reg_freq();
        t_spread_tristate();
        t_enables();
        t_oob_write();
        t_mobile();
      end
      begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule